// File: doc/BRIEF.md
# Clock-Manager Lock-Loss Reset Generator

This block supervises the lock flag of a clock-synthesis unit whose input clock comes from an external PHY and may stop at any time. All decisions are made on a separate reference clock that never stops. When lock drops, the block issues a reset request. While lock stays absent, a retry timer re-issues the request at a fixed interval until the unit locks again.

Each request is carried into the unit's input-clock domain over a level handshake and stretched there into a short reset pulse. A request raised while that clock is stopped is held until the clock runs again. A second, long reset output is stretched on the reference clock to a minimum duration. It can also be driven directly from a dedicated input, so that a bench can use a short pulse instead of the full duration.

Top module: `lockloss_rst_gen`

## Requirements
- R1: The lock input passes through SYNC_STAGES reference-clock flops. A high-to-low change of the synchronized lock issues one reset request.
- R2: While the synchronized lock is low, a retry counter runs on the reference clock. Every TIMEOUT_CYC cycles it issues a further request, so consecutive requests are TIMEOUT_CYC reference cycles apart.
- R3: While the synchronized lock is high, the retry counter is held at zero and no request is issued.
- R4: While sys_rst is high, unit_rst_o and long_rst_o are low and the retry counter is cleared. After reset the lock is treated as absent, and exactly one request is forced without any lock edge.
- R5: Each request delivered to the input-clock domain drives unit_rst_o high for exactly STRETCH_CYC consecutive in_clk cycles. The default STRETCH_CYC is 3.
- R6: A request issued while in_clk is stopped is not lost. It stays pending and produces its pulse once in_clk runs again. Requests raised while one is still in flight are merged into one follow-up pulse.
- R7: With LONG_EN set, long_rst_o rises two reference cycles after each request. It stays high for LONG_CYC reference cycles after the latest request, then falls if no further request arrives.
- R8: long_rst_o is also high one reference cycle after long_rst_i is high, independent of requests. long_rst_i never causes a pulse on unit_rst_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running reference clock for all control logic |
| in_clk | input | 1 | Input clock of the clock-synthesis unit; may stop |
| sys_rst | input | 1 | Synchronous active-high system reset, reference domain |
| lock_i | input | 1 | Lock status of the clock-synthesis unit, asynchronous |
| long_rst_i | input | 1 | Direct drive of the long reset, for short start-up pulses |
| unit_rst_o | output | 1 | Short reset to the clock unit, in_clk domain |
| long_rst_o | output | 1 | Long minimum-duration reset, reference domain |

## Verification
On every cycle, the assertions check the following:
- the retry counter stays in range and is cleared while locked;
- no request appears while lock is stable;
- the handshake request holds until it is acknowledged, and a request never vanishes before it is launched;
- reset leaves a forced request behind;
- every unit_rst_o pulse lasts exactly the stretch length.

Only the bench scenarios can show the end-to-end effects:
- the spacing of retry pulses at the ports;
- retries stopping on re-lock;
- the long output falling after its window;
- a pulse surviving a stopped in_clk and being delivered, together with one merged follow-up, once the clock resumes.

// File: rtl/lrg_pkg.sv
package lrg_pkg;
  // width of a counter that must hold values 0..n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/lrg_lock_mon.sv
module lrg_lock_mon
  import lrg_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 150000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              lock_i,
  output logic                              locked_o,
  output logic                              req_evt_o,
  output logic [cnt_w(TIMEOUT_CYC)-1:0]     tmo_cnt_o
);
  localparam int unsigned CW = cnt_w(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [SYNC_STAGES-1:0] lk_sr;
  logic                   locked_q;
  logic [CW-1:0]          tmo_cnt;
  logic                   lost_edge;
  logic                   expiry;

  assign locked_o  = lk_sr[SYNC_STAGES-1];
  assign lost_edge = locked_q & ~locked_o;
  assign expiry    = ~locked_o & (tmo_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_sr    <= '0;
      locked_q <= 1'b0;
    end else begin
      lk_sr    <= {lk_sr[SYNC_STAGES-2:0], lock_i};
      locked_q <= locked_o;
    end
  end

  // retry timer: runs only while lock is absent, wraps on expiry
  always_ff @(posedge clk) begin
    if (rst || locked_o || expiry) tmo_cnt <= '0;
    else                           tmo_cnt <= tmo_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) req_evt_o <= 1'b0;
    else     req_evt_o <= lost_edge | expiry;
  end

  assign tmo_cnt_o = tmo_cnt;
endmodule

// File: rtl/lrg_req_xfer.sv
module lrg_req_xfer
  import lrg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STRETCH_CYC = 3
) (
  input  logic ref_clk,
  input  logic ref_rst,
  input  logic req_evt_i,
  input  logic in_clk,
  output logic unit_rst_o,
  output logic pend_o,
  output logic req_lvl_o,
  output logic ack_sync_o,
  output logic in_rst_o
);
  localparam int unsigned SW = cnt_w(STRETCH_CYC);
  localparam logic [SW-1:0] LOAD = SW'(STRETCH_CYC);

  // ---------------- reference side ----------------
  logic                   pend;
  logic                   req_lvl;
  logic [SYNC_STAGES-1:0] ack_sr;
  logic                   launch;
  logic                   ack_s;

  assign ack_s  = ack_sr[SYNC_STAGES-1];
  assign launch = pend & ~req_lvl & ~ack_s;

  always_ff @(posedge ref_clk) begin
    if (ref_rst) begin
      pend    <= 1'b1;            // reset forces one request
      req_lvl <= 1'b0;
    end else begin
      pend <= req_evt_i | (pend & ~launch);
      if (launch)                req_lvl <= 1'b1;
      else if (req_lvl && ack_s) req_lvl <= 1'b0;
    end
  end

  // ---------------- input-clock side ----------------
  logic [SYNC_STAGES-1:0] in_rst_sr;
  logic [SYNC_STAGES-1:0] req_sr;
  logic                   req_q;
  logic                   rise;
  logic [SW-1:0]          st_cnt;
  logic                   rst_q;

  assign in_rst_o = in_rst_sr[SYNC_STAGES-1];
  assign rise     = req_sr[SYNC_STAGES-1] & ~req_q;

  always_ff @(posedge in_clk) begin
    in_rst_sr <= {in_rst_sr[SYNC_STAGES-2:0], ref_rst};
  end

  always_ff @(posedge in_clk) begin
    if (in_rst_o) begin
      req_sr <= '0;
      req_q  <= 1'b0;
      st_cnt <= '0;
      rst_q  <= 1'b0;
    end else begin
      req_sr <= {req_sr[SYNC_STAGES-2:0], req_lvl};
      req_q  <= req_sr[SYNC_STAGES-1];
      if (rise) begin
        st_cnt <= LOAD;
        rst_q  <= 1'b1;
      end else if (st_cnt > SW'(1)) begin
        st_cnt <= st_cnt - 1'b1;
        rst_q  <= 1'b1;
      end else begin
        st_cnt <= '0;
        rst_q  <= 1'b0;
      end
    end
  end

  // acknowledge returns to the reference domain
  always_ff @(posedge ref_clk) begin
    if (ref_rst) ack_sr <= '0;
    else         ack_sr <= {ack_sr[SYNC_STAGES-2:0], req_q};
  end

  assign unit_rst_o = rst_q;
  assign pend_o     = pend;
  assign req_lvl_o  = req_lvl;
  assign ack_sync_o = ack_s;
endmodule

// File: rtl/lrg_long_stretch.sv
module lrg_long_stretch
  import lrg_pkg::*;
#(
  parameter bit          LONG_EN  = 1'b1,
  parameter int unsigned LONG_CYC = 25000000
) (
  input  logic clk,
  input  logic rst,
  input  logic req_evt_i,
  input  logic ext_i,
  output logic long_o
);
  localparam int unsigned LW = cnt_w(LONG_CYC);

  generate
    if (LONG_EN) begin : g_timer
      logic [LW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (req_evt_i)     cnt <= LW'(LONG_CYC);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
      end
      always_ff @(posedge clk) begin
        if (rst) long_o <= 1'b0;
        else     long_o <= (cnt != '0) | ext_i;
      end
    end else begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) long_o <= 1'b0;
        else     long_o <= ext_i;
      end
    end
  endgenerate
endmodule

// File: rtl/lockloss_rst_gen.sv
module lockloss_rst_gen
  import lrg_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 150000,
  parameter int unsigned STRETCH_CYC = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          LONG_EN     = 1'b1,
  parameter int unsigned LONG_CYC    = 25000000
) (
  input  logic ref_clk,
  input  logic in_clk,
  input  logic sys_rst,
  input  logic lock_i,
  input  logic long_rst_i,
  output logic unit_rst_o,
  output logic long_rst_o
);
  localparam int unsigned CW = cnt_w(TIMEOUT_CYC);

  logic          locked;
  logic          req_evt;
  logic [CW-1:0] tmo_cnt;
  logic          pend;
  logic          req_lvl;
  logic          ack_s;
  logic          in_rst;

  lrg_lock_mon #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) mon_i (
    .clk       (ref_clk),
    .rst       (sys_rst),
    .lock_i    (lock_i),
    .locked_o  (locked),
    .req_evt_o (req_evt),
    .tmo_cnt_o (tmo_cnt)
  );

  lrg_req_xfer #(
    .SYNC_STAGES (SYNC_STAGES),
    .STRETCH_CYC (STRETCH_CYC)
  ) xfer_i (
    .ref_clk    (ref_clk),
    .ref_rst    (sys_rst),
    .req_evt_i  (req_evt),
    .in_clk     (in_clk),
    .unit_rst_o (unit_rst_o),
    .pend_o     (pend),
    .req_lvl_o  (req_lvl),
    .ack_sync_o (ack_s),
    .in_rst_o   (in_rst)
  );

  lrg_long_stretch #(
    .LONG_EN  (LONG_EN),
    .LONG_CYC (LONG_CYC)
  ) long_i (
    .clk       (ref_clk),
    .rst       (sys_rst),
    .req_evt_i (req_evt),
    .ext_i     (long_rst_i),
    .long_o    (long_rst_o)
  );
endmodule

// File: rtl/lrg_checker.sv
module lrg_checker
  import lrg_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 150000,
  parameter int unsigned STRETCH_CYC = 3,
  parameter bit          LONG_EN     = 1'b1
) (
  input logic                          ref_clk,
  input logic                          in_clk,
  input logic                          sys_rst,
  input logic                          in_rst,
  input logic                          locked,
  input logic                          req_evt,
  input logic [cnt_w(TIMEOUT_CYC)-1:0] tmo_cnt,
  input logic                          pend,
  input logic                          req_lvl,
  input logic                          ack_s,
  input logic                          unit_rst_o,
  input logic                          long_rst_o
);
  int unsigned hi_cnt;
  always_ff @(posedge in_clk) begin
    if (in_rst)          hi_cnt <= 0;
    else if (unit_rst_o) hi_cnt <= hi_cnt + 1;
    else                 hi_cnt <= 0;
  end

  AST_TMO_RANGE: assert property (@(posedge ref_clk) disable iff (sys_rst)
    tmo_cnt < cnt_w(TIMEOUT_CYC)'(TIMEOUT_CYC)); // R2
  AST_CNT_CLR_LOCK: assert property (@(posedge ref_clk) disable iff (sys_rst)
    locked |=> tmo_cnt == '0); // R3
  AST_NO_EVT_LOCKED: assert property (@(posedge ref_clk) disable iff (sys_rst)
    locked && $past(locked) |-> !req_evt); // R3
  AST_RST_PEND: assert property (@(posedge ref_clk) disable iff (sys_rst)
    $fell(sys_rst) |-> pend); // R4
  AST_REQ_HOLD: assert property (@(posedge ref_clk) disable iff (sys_rst)
    req_lvl && !ack_s |=> req_lvl); // R6
  AST_EVT_KEPT: assert property (@(posedge ref_clk) disable iff (sys_rst)
    req_evt |=> (pend || req_lvl)); // R6
  AST_LONG_FOLLOWS: assert property (@(posedge ref_clk) disable iff (sys_rst)
    LONG_EN && req_evt |=> ##1 long_rst_o); // R7
  AST_PULSE_MAX: assert property (@(posedge in_clk) disable iff (in_rst)
    unit_rst_o |-> hi_cnt < STRETCH_CYC); // R5
  AST_PULSE_FULL: assert property (@(posedge in_clk) disable iff (in_rst)
    $fell(unit_rst_o) |-> hi_cnt == STRETCH_CYC); // R5
endmodule

bind lockloss_rst_gen lrg_checker #(
  .TIMEOUT_CYC (TIMEOUT_CYC),
  .STRETCH_CYC (STRETCH_CYC),
  .LONG_EN     (LONG_EN)
) chk_i (
  .ref_clk    (ref_clk),
  .in_clk     (in_clk),
  .sys_rst    (sys_rst),
  .in_rst     (in_rst),
  .locked     (locked),
  .req_evt    (req_evt),
  .tmo_cnt    (tmo_cnt),
  .pend       (pend),
  .req_lvl    (req_lvl),
  .ack_s      (ack_s),
  .unit_rst_o (unit_rst_o),
  .long_rst_o (long_rst_o)
);

// File: tb/lockloss_rst_gen_tb_top.sv
`timescale 1ns/1ps
module lockloss_rst_gen_tb_top;
  localparam int TMO  = 50;
  localparam int STR  = 3;
  localparam int LNG  = 20;

  logic ref_clk = 1'b0;
  logic in_clk  = 1'b0;
  logic in_run  = 1'b1;
  logic sys_rst = 1'b1;
  logic lock_i  = 1'b0;
  logic long_rst_i = 1'b0;
  logic unit_rst_o;
  logic long_rst_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 ref_clk = ~ref_clk;
  always #4 if (in_run) in_clk = ~in_clk;
  always @(posedge ref_clk) cyc <= cyc + 1;

  lockloss_rst_gen #(
    .TIMEOUT_CYC (TMO),
    .STRETCH_CYC (STR),
    .SYNC_STAGES (2),
    .LONG_EN     (1'b1),
    .LONG_CYC    (LNG)
  ) dut_i (
    .ref_clk    (ref_clk),
    .in_clk     (in_clk),
    .sys_rst    (sys_rst),
    .lock_i     (lock_i),
    .long_rst_i (long_rst_i),
    .unit_rst_o (unit_rst_o),
    .long_rst_o (long_rst_o)
  );

  // pulse monitor in the input-clock domain
  int pulse_cnt = 0;
  int cur_w = 0;
  int last_w = 0;
  int rise_t = 0;
  int prev_rise_t = 0;
  always @(negedge in_clk) begin
    if (unit_rst_o) begin
      if (cur_w == 0) begin
        prev_rise_t = rise_t;
        rise_t = cyc;
      end
      cur_w = cur_w + 1;
    end else if (cur_w != 0) begin
      last_w = cur_w;
      pulse_cnt = pulse_cnt + 1;
      cur_w = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_ref(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic t_reset();
    sys_rst = 1'b1;
    lock_i  = 1'b0;
    wait_ref(10);
    chk("R4 unit_rst_o low in reset", int'(unit_rst_o), 0);
    chk("R4 long_rst_o low in reset", int'(long_rst_o), 0);
    lock_i  = 1'b1;
    sys_rst = 1'b0;
    wait_ref(60);
    chk("R4 forced pulse after reset", pulse_cnt, 1);
    chk("R5 pulse width", last_w, STR);
    wait_ref(3 * TMO);
    chk("R3 no retry while locked", pulse_cnt, 1);
  endtask

  task automatic t_lockloss();
    int base;
    base = pulse_cnt;
    lock_i = 1'b0;
    wait_ref(6);
    chk("R7 long_rst_o high after request", int'(long_rst_o), 1);
    wait_ref(9);
    lock_i = 1'b1;
    wait_ref(LNG + 17 - 15);
    chk("R7 long_rst_o falls after window", int'(long_rst_o), 0);
    wait_ref(3 * TMO);
    chk("R1 single pulse on lock loss", pulse_cnt, base + 1);
    chk("R5 lock-loss pulse width", last_w, STR);
  endtask

  task automatic t_retry();
    int base;
    base = pulse_cnt;
    lock_i = 1'b0;
    wait_ref(4 * TMO + 20);
    chk("R2 retry pulse count", pulse_cnt, base + 5);
    chk_rng("R2 retry interval", rise_t - prev_rise_t, TMO - 3, TMO + 3);
    chk("R5 retry pulse width", last_w, STR);
    lock_i = 1'b1;
    wait_ref(10);
    base = pulse_cnt;
    wait_ref(3 * TMO);
    chk("R3 re-lock stops retries", pulse_cnt, base);
  endtask

  task automatic t_stopped();
    int base;
    base = pulse_cnt;
    wait_ref(2);
    in_run = 1'b0;
    wait_ref(4);
    lock_i = 1'b0;
    wait_ref(2 * TMO + 10);
    chk("R6 no pulse while in_clk stopped", pulse_cnt, base);
    chk("R6 unit_rst_o idle while stopped", int'(unit_rst_o), 0);
    lock_i = 1'b1;
    wait_ref(5);
    in_run = 1'b1;
    wait_ref(80);
    chk("R6 pending pulse plus merged follow-up", pulse_cnt, base + 2);
    chk("R5 delayed pulse width", last_w, STR);
  endtask

  task automatic t_long_in();
    int base;
    base = pulse_cnt;
    long_rst_i = 1'b1;
    wait_ref(1);
    chk("R8 long_rst_i drives long_rst_o", int'(long_rst_o), 1);
    wait_ref(2);
    long_rst_i = 1'b0;
    wait_ref(2);
    chk("R8 long_rst_o released", int'(long_rst_o), 0);
    wait_ref(30);
    chk("R8 no unit pulse from long_rst_i", pulse_cnt, base);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_lockloss();
        t_retry();
        t_stopped();
        t_long_in();
      end
      begin
        wait_ref(20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule